// File: doc/BRIEF.md
# Restartable Dead-Time Generator

This block turns a single source waveform into two complementary outputs that never overlap. The space between them is a programmable dead time. A mode input selects the source. It is either a compare-match level from a timer or a pulse-train input from a pulse generator. The source that is not selected is ignored completely.

Every change of the source level, rising or falling, reloads a down-counter from the dead-time setting. The output that must switch off does so on the clock edge that sees the source change. The output that must switch on waits until the counter has run out. A new source edge during a running count restarts the count. A source pulse narrower than the dead time therefore never reaches the delayed output.

A polarity input inverts both outputs. While the block is disabled or in reset, both outputs sit at their inactive level. When the block is enabled, or when the source selection changes while it is enabled, the outputs are preloaded from the current source level.

Top module: `dead_time_gen`

## Requirements
- R1: While `rst_n` is low or `enable` is low, both outputs are inactive. The inactive level is 0 with `polarity`=0 and 1 with `polarity`=1. Source activity has no effect during that time.
- R2: On the first enabled clock edge, the outputs are preloaded from the selected source level. With `polarity`=0, `out0` takes the source level and `out1` takes its inverse. With `polarity`=1, these two assignments are swapped. The preloaded levels appear one cycle after `enable` is raised.
- R3: A rising source level changes `out1` to inactive on the clock edge that samples it. `out0` becomes active `dead_time`+1 clock edges later.
- R4: A falling source level changes `out0` to inactive on the clock edge that samples it. `out1` becomes active `dead_time`+1 clock edges later.
- R5: A source edge that arrives while a count is running reloads and restarts the count. A pulse narrower than the dead time therefore gives no pulse on `out0`. `out1` then becomes active `dead_time`+1 edges after the falling edge.
- R6: With `dead_time`=0, the turn-on happens on the clock edge right after the edge that turned the other output off.
- R7: `polarity`=1 inverts both outputs relative to `polarity`=0, and it takes effect on the outputs without any clock delay.
- R8: With `mode_sel`=0, only `cmp_src` drives the block. With `mode_sel`=1, only `pulse_src` drives the block. The unselected input has no effect.
- R9: The two outputs are never active at the same time.
- R10: A change of `mode_sel` while the block is enabled acts as a fresh mode entry. It preloads the outputs from the newly selected source, as in R2, and cancels any running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces both outputs inactive |
| mode_sel | input | 1 | Source select: 0 compare signal, 1 pulse train |
| polarity | input | 1 | 0 active-high outputs, 1 active-low outputs |
| dead_time | input | 16 | Dead time in clock cycles, sampled on each source edge |
| cmp_src | input | 1 | Compare-match source signal |
| pulse_src | input | 1 | Pulse-train source signal |
| out0 | output | 1 | Output that follows the source high phase, delayed on turn-on |
| out1 | output | 1 | Output that follows the source low phase, delayed on turn-on |

## Verification
The bench places the turn-off and turn-on events exactly on the cycle where they belong. It checks the cycle just before each turn-on, so a counter that is off by one in either direction fails that check.

A short-pulse case checks the restart rule. A design that let the first count run to its end would leave a stray `out0` pulse, and one that ignored the second edge would hold `out1` low for good.

The zero-dead-time case catches a counter that underflows or that never reports expiry at zero. Toggling the unselected source catches a wrong multiplexer or a missing mode-entry preload. Changing the polarity and enable states catches a polarity applied only to one output, or a disabled level that ignores polarity.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  // Source selection encoding carried on mode_sel
  typedef enum logic {
    SRC_CMP   = 1'b0,
    SRC_PULSE = 1'b1
  } src_sel_e;

  // Which output is waiting for the dead time to run out
  typedef enum logic {
    TGT_OUT0 = 1'b0,
    TGT_OUT1 = 1'b1
  } turn_on_tgt_e;

  localparam int unsigned DTG_DEF_CNT_W = 16;

endpackage

// File: rtl/dtg_edge.sv
module dtg_edge
  import dtg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic mode_sel,
  input  logic cmp_src,
  input  logic pulse_src,
  output logic src_now,
  output logic entry,
  output logic rise,
  output logic fall
);

  src_sel_e sel;
  logic     src_q, src_d;
  logic     en_q, en_d;
  logic     mode_q, mode_d;

  assign sel = src_sel_e'(mode_sel);

  // Source multiplexer
  always_comb begin
    unique case (sel)
      SRC_CMP:   src_now = cmp_src;
      SRC_PULSE: src_now = pulse_src;
      default:   src_now = 1'b0;
    endcase
  end

  // Mode entry and edge qualification
  always_comb begin
    entry = enable && (!en_q || (mode_sel != mode_q));
    rise  = enable && !entry && src_now && !src_q;
    fall  = enable && !entry && !src_now && src_q;
    src_d  = src_now;
    en_d   = enable;
    mode_d = mode_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/dtg_counter.sv
module dtg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    expire = 1'b0;
    if (stop) begin
      run_d = 1'b0;
    end else if (load) begin
      run_d  = 1'b1;
      cnt_d  = value;
      cnt_en = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d  = 1'b0;
        expire = 1'b1;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // A finished count cannot report expiry on two consecutive cycles (R6)
  assert_expire_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  // A stop request always cancels a running count (R10)
  assert_stop_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !expire);

endmodule

// File: rtl/dtg_out_ctrl.sv
module dtg_out_ctrl
  import dtg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic entry,
  input  logic rise,
  input  logic fall,
  input  logic expire,
  input  logic src_now,
  output logic act0,
  output logic act1
);

  logic         act0_d, act1_d;
  turn_on_tgt_e tgt_q, tgt_d;

  always_comb begin
    act0_d = act0;
    act1_d = act1;
    tgt_d  = tgt_q;
    if (!enable) begin
      act0_d = 1'b0;
      act1_d = 1'b0;
    end else if (entry) begin
      act0_d = src_now;
      act1_d = !src_now;
    end else if (rise) begin
      act1_d = 1'b0;
      tgt_d  = TGT_OUT0;
    end else if (fall) begin
      act0_d = 1'b0;
      tgt_d  = TGT_OUT1;
    end else if (expire) begin
      if (tgt_q == TGT_OUT0) act0_d = 1'b1;
      else                   act1_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act0  <= 1'b0;
      act1  <= 1'b0;
      tgt_q <= TGT_OUT0;
    end else begin
      act0  <= act0_d;
      act1  <= act1_d;
      tgt_q <= tgt_d;
    end
  end

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(act0 && act1));

  assert_rise_turns_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !act1);

  assert_fall_turns_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !act0);

  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!act0 && !act1));

  assert_entry_preload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (act0 == $past(src_now)) && (act1 == !$past(src_now)));

endmodule

// File: rtl/dead_time_gen.sv
module dead_time_gen
  import dtg_pkg::*;
#(
  parameter int unsigned CNT_W = DTG_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode_sel,
  input  logic             polarity,
  input  logic [CNT_W-1:0] dead_time,
  input  logic             cmp_src,
  input  logic             pulse_src,
  output logic             out0,
  output logic             out1
);

  logic src_now, entry, rise, fall;
  logic expire, cnt_stop, cnt_load;
  logic act0, act1;

  dtg_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .mode_sel  (mode_sel),
    .cmp_src   (cmp_src),
    .pulse_src (pulse_src),
    .src_now   (src_now),
    .entry     (entry),
    .rise      (rise),
    .fall      (fall)
  );

  assign cnt_stop = !enable || entry;
  assign cnt_load = rise || fall;

  dtg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .stop   (cnt_stop),
    .load   (cnt_load),
    .value  (dead_time),
    .expire (expire)
  );

  dtg_out_ctrl u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .entry   (entry),
    .rise    (rise),
    .fall    (fall),
    .expire  (expire),
    .src_now (src_now),
    .act0    (act0),
    .act1    (act1)
  );

  // Polarity applies to the logical state with no register delay (R7)
  assign out0 = act0 ^ polarity;
  assign out1 = act1 ^ polarity;

  // A turn-on only ever follows a quiet cycle of the source (R5)
  assert_turn_on_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act0) |-> $past(!cnt_load) && !$past(!enable));

endmodule

// File: tb/tb_dead_time_gen.sv
module tb_dead_time_gen;

  localparam int unsigned W = 16;

  typedef struct {
    int    cyc;
    logic  e0;
    logic  e1;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         mode_sel = 1'b0;
  logic         polarity = 1'b0;
  logic [W-1:0] dead_time = '0;
  logic         cmp_src = 1'b0;
  logic         pulse_src = 1'b0;
  logic         out0, out1;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  exp_t sb[$];

  dead_time_gen #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_sel(mode_sel),
    .polarity(polarity), .dead_time(dead_time), .cmp_src(cmp_src),
    .pulse_src(pulse_src), .out0(out0), .out1(out1)
  );

  always #2ns clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic g0, logic g1, logic e0, logic e1);
    n_checks++;
    if (g0 !== e0 || g1 !== e1) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual out0=%b out1=%b expected out0=%b out1=%b",
               tag, cyc, g0, g1, e0, e1);
    end
  endtask

  // Driver side: expect given levels 'delta' cycles from now (delta >= 1)
  task automatic expect_at(int delta, logic e0, logic e1, string tag);
    exp_t it;
    it.cyc = cyc + delta;
    it.e0  = e0;
    it.e1  = e1;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Advance to the driving point of a later cycle
  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1ns;
  endtask

  // Monitor: compare at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      if (it.cyc < cyc) check({it.tag, " (missed slot)"}, out0, out1, ~out0, ~out1);
      else              check(it.tag, out0, out1, it.e0, it.e1);
    end
  end

  task automatic finish_run();
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      n_checks++;
      n_fail++;
      $display("FAIL %s never checked, expected out0=%b out1=%b", it.tag, it.e0, it.e1);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state, active-high
    step(2);
    check("R1 reset", out0, out1, 1'b0, 1'b0);
    rst_n = 1'b1;
    dead_time = 16'd5;
    step(1);
    // R1: disabled block ignores source activity
    cmp_src = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R1 disabled");
    expect_at(3, 1'b0, 1'b0, "R1 disabled");
    step(4);

    // R2: entry with source high, normal polarity
    enable = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R2 entry normal");
    step(3);

    // R4: falling edge, dead time 5
    cmp_src = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R4 off at once");
    expect_at(6, 1'b0, 1'b0, "R4 before expiry");
    expect_at(7, 1'b0, 1'b1, "R4 turn-on");
    step(9);

    // R3: rising edge, dead time 5
    cmp_src = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R3 off at once");
    expect_at(6, 1'b0, 1'b0, "R3 before expiry");
    expect_at(7, 1'b1, 1'b0, "R3 turn-on");
    step(9);

    // R8: pulse input ignored in compare mode
    pulse_src = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R8 pulse ignored");
    step(2);
    pulse_src = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R8 pulse ignored");
    expect_at(8, 1'b1, 1'b0, "R8 pulse ignored");
    step(9);

    // Settle low before the short pulse
    cmp_src = 1'b0;
    expect_at(7, 1'b0, 1'b1, "R4 settle");
    step(9);

    // R5: pulse of 2 cycles, shorter than dead time 5
    cmp_src = 1'b1;
    for (int k = 1; k <= 8; k++) expect_at(k, 1'b0, 1'b0, "R5 no out0 pulse");
    expect_at(9, 1'b0, 1'b1, "R5 out1 after restart");
    step(2);
    cmp_src = 1'b0;
    step(10);

    // R6: zero dead time
    dead_time = 16'd0;
    step(1);
    cmp_src = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R6 off");
    expect_at(2, 1'b1, 1'b0, "R6 next-cycle turn-on");
    step(4);

    // R7: polarity inverts both outputs with no delay
    polarity = 1'b1;
    #0.5ns;
    check("R7 immediate invert", out0, out1, 1'b0, 1'b1);
    expect_at(1, 1'b0, 1'b1, "R7 inverted");
    step(2);
    cmp_src = 1'b0;
    expect_at(1, 1'b1, 1'b1, "R7 both inactive");
    expect_at(2, 1'b1, 1'b0, "R7 inverted turn-on");
    step(4);

    // R1: disabled with reversed polarity shows level 1
    enable = 1'b0;
    expect_at(1, 1'b1, 1'b1, "R1 disabled reversed");
    step(3);
    // R2: entry with source low, reversed polarity
    enable = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R2 entry reversed");
    step(3);
    polarity = 1'b0;
    step(1);

    // R10: mode change with pulse input high preloads from it
    dead_time = 16'd3;
    pulse_src = 1'b1;
    mode_sel  = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R10 mode re-entry");
    step(2);
    // R8: compare input ignored in pulse mode
    cmp_src = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R8 cmp ignored");
    step(2);
    cmp_src = 1'b0;
    expect_at(2, 1'b1, 1'b0, "R8 cmp ignored");
    step(3);
    // R4 in pulse mode, dead time 3
    pulse_src = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R4 pulse off");
    expect_at(4, 1'b0, 1'b0, "R4 pulse before expiry");
    expect_at(5, 1'b0, 1'b1, "R4 pulse turn-on");
    step(6);

    // R1: disable during a count leaves no stale turn-on
    pulse_src = 1'b1;
    step(1);
    enable = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R1 disable mid-count");
    expect_at(5, 1'b0, 1'b0, "R1 no stale turn-on");
    step(6);

    finish_run();
  end

endmodule